// File: doc/BRIEF.md
# Key-Sequence Write Unlock Gate

This block stands between a register-write bus and a peripheral register file and decides, write by write, whether a write may reach the registers. A window of protected addresses can only be written once software has performed an unlock ritual. The ritual has two steps. A first 32-bit key value goes to one key address. A second, different 32-bit key value then goes to a second key address. Any wrong value written to the first key address throws the gate back into the locked state. The second key is also refused, with a return to the locked state, if it carries a wrong value or arrives without a valid first key before it.

The gate does not hold the protected registers. It produces a write qualifier, `wr_allow_o`, that the register file ANDs into its write enables. It also produces a pulse telling the bus that a key register consumed the write, and a locked status. On the read side it forces the key addresses to read as zero, so key values can never be read back.

Decisions about a write are combinational on the current lock state. A key write changes the lock state at the clock edge that ends its cycle.

Top module: `key_unlock_gate`

## Requirements
- R1: While reset is asserted, and after it is released, `locked_o` is 1. With no write in progress, `wr_allow_o` and `key_wr_o` are 0.
- R2: The gate opens through the following sequence, and `locked_o` falls in the cycle after the second write:
  - a full-width write of 0x83E70B13 to byte address 0x6C;
  - then a full-width write of 0x95A4F1E0 to byte address 0x70.
  Writes to non-key addresses between the two key writes do not break the sequence.
- R3: A write to the protected window (byte addresses 0x00 to 0x5F) is blocked while `locked_o` is 1: `wr_allow_o` stays 0. While the gate is open, `wr_allow_o` equals `wr_en_i` in the same cycle.
- R4: A write to an address outside the protected window that is not a key address always gets `wr_allow_o` equal to `wr_en_i`, whatever the lock state.
- R5: A write to either key address is always consumed, in every state. `key_wr_o` is 1 in that cycle and `wr_allow_o` is 0.
- R6: A write to 0x6C with any value other than 0x83E70B13, zero included, leaves the gate locked from the next cycle. This holds whatever the previous state.
- R7: A write to 0x70 leaves the gate locked from the next cycle in either of these cases:
  - no valid first key is pending;
  - the value written is not 0x95A4F1E0.
- R8: A key write whose byte strobes (`wr_strb_i`, one bit per byte) are not all 1 counts as a wrong key value.
- R9: `rd_data_o` is 0 when `rd_addr_i` is 0x6C or 0x70. Otherwise it passes `rd_data_i` through unchanged.
- R10: After only the first key has been accepted, `locked_o` stays 1 and protected writes stay blocked.
- R11: While open, writing the correct value to either key address keeps the gate open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | DATA_W | Write data |
| wr_strb_i | input | DATA_W/8 | Byte strobes of the write |
| rd_addr_i | input | ADDR_W | Byte address of the current read |
| rd_data_i | input | DATA_W | Read data from the register file |
| rd_data_o | output | DATA_W | Read data, with key addresses forced to zero |
| wr_allow_o | output | 1 | Write qualifier for the register file |
| key_wr_o | output | 1 | Write was consumed by a key register |
| locked_o | output | 1 | High unless the gate is fully open |

## Verification
The two write outputs, `wr_allow_o` and `key_wr_o`, are combinational on the current lock state. The bench therefore checks them one time unit after driving a write at the falling edge, before the rising edge that ends that write. The lock state changes at that rising edge, so `locked_o` is checked one time unit after it. The read mux has no register and is checked in the same half cycle as the read address is set. The main sweep brings the gate into each of the three states (locked, first key pending, open) and then writes every word address with several data values, including both keys and zero. The outcome of each write is predicted by an arithmetic model kept in the bench.

// File: rtl/unlock_gate_pkg.sv
package unlock_gate_pkg;

    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_st_e;

    typedef struct packed {
        gate_st_e st;
    } gate_regs_t;

endpackage

// File: rtl/unlock_key_decode.sv
module unlock_key_decode #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] KEY_A_ADDR = 8'h6C,
    parameter logic [ADDR_W-1:0] KEY_B_ADDR = 8'h70,
    parameter logic [DATA_W-1:0] KEY_A_VAL  = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY_B_VAL  = 32'h95A4_F1E0,
    parameter logic [ADDR_W-1:0] PROT_LO    = 8'h00,
    parameter logic [ADDR_W-1:0] PROT_HI    = 8'h5F
) (
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [DATA_W/8-1:0] wr_strb_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic                hit_a_o,
    output logic                hit_b_o,
    output logic                good_a_o,
    output logic                good_b_o,
    output logic                in_prot_o,
    output logic                rd_key_o
);

    localparam logic [ADDR_W-1:0] PROT_SPAN = PROT_HI - PROT_LO;

    logic               full_word;
    logic [ADDR_W-1:0]  prot_ofs;

    always_comb begin
        full_word = &wr_strb_i;
        hit_a_o   = (wr_addr_i == KEY_A_ADDR);
        hit_b_o   = (wr_addr_i == KEY_B_ADDR);
        good_a_o  = full_word && (wr_data_i == KEY_A_VAL);
        good_b_o  = full_word && (wr_data_i == KEY_B_VAL);
        prot_ofs  = wr_addr_i - PROT_LO;
        in_prot_o = (prot_ofs <= PROT_SPAN) && !hit_a_o && !hit_b_o;
        rd_key_o  = (rd_addr_i == KEY_A_ADDR) || (rd_addr_i == KEY_B_ADDR);
    end

endmodule

// File: rtl/unlock_fsm.sv
module unlock_fsm
    import unlock_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic hit_a_i,
    input  logic hit_b_i,
    input  logic good_a_i,
    input  logic good_b_i,
    output logic locked_o
);

    gate_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i && hit_a_i) begin
            if (!good_a_i)
                regs_d.st = GATE_LOCKED;
            else if (regs_q.st != GATE_OPEN)
                regs_d.st = GATE_ARMED;
        end else if (wr_en_i && hit_b_i) begin
            if (good_b_i && (regs_q.st != GATE_LOCKED))
                regs_d.st = GATE_OPEN;
            else
                regs_d.st = GATE_LOCKED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= '{st: GATE_LOCKED};
        else
            regs_q <= regs_d;
    end

    assign locked_o = (regs_q.st != GATE_OPEN);

    AST_OPEN_NEEDS_KEY_B: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == GATE_OPEN && $past(regs_q.st) != GATE_OPEN)
            |-> $past(wr_en_i && hit_b_i && good_b_i)); // R2

    AST_ARMED_NEEDS_KEY_A: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == GATE_ARMED && $past(regs_q.st) != GATE_ARMED)
            |-> $past(wr_en_i && hit_a_i && good_a_i)); // R10

    AST_BAD_KEY_A_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && hit_a_i && !good_a_i) |=> (regs_q.st == GATE_LOCKED)); // R6

    AST_EARLY_KEY_B_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && hit_b_i && regs_q.st == GATE_LOCKED) |=> locked_o); // R7

endmodule

// File: rtl/unlock_write_qual.sv
module unlock_write_qual #(
    parameter int DATA_W = 32
) (
    input  logic              wr_en_i,
    input  logic              hit_a_i,
    input  logic              hit_b_i,
    input  logic              in_prot_i,
    input  logic              locked_i,
    input  logic              rd_key_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_allow_o,
    output logic              key_wr_o,
    output logic [DATA_W-1:0] rd_data_o
);

    logic key_hit;

    always_comb begin
        key_hit    = hit_a_i || hit_b_i;
        key_wr_o   = wr_en_i && key_hit;
        wr_allow_o = wr_en_i && !key_hit && (!in_prot_i || !locked_i);
        rd_data_o  = rd_key_i ? '0 : rd_data_i;
    end

endmodule

// File: rtl/key_unlock_gate.sv
module key_unlock_gate #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] KEY_A_ADDR = 8'h6C,
    parameter logic [ADDR_W-1:0] KEY_B_ADDR = 8'h70,
    parameter logic [DATA_W-1:0] KEY_A_VAL  = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY_B_VAL  = 32'h95A4_F1E0,
    parameter logic [ADDR_W-1:0] PROT_LO    = 8'h00,
    parameter logic [ADDR_W-1:0] PROT_HI    = 8'h5F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [DATA_W/8-1:0] wr_strb_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    input  logic [DATA_W-1:0]   rd_data_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                wr_allow_o,
    output logic                key_wr_o,
    output logic                locked_o
);

    logic hit_a, hit_b, good_a, good_b, in_prot, rd_key;

    unlock_key_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .KEY_A_ADDR (KEY_A_ADDR),
        .KEY_B_ADDR (KEY_B_ADDR),
        .KEY_A_VAL  (KEY_A_VAL),
        .KEY_B_VAL  (KEY_B_VAL),
        .PROT_LO    (PROT_LO),
        .PROT_HI    (PROT_HI)
    ) i_decode (
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .wr_strb_i  (wr_strb_i),
        .rd_addr_i  (rd_addr_i),
        .hit_a_o    (hit_a),
        .hit_b_o    (hit_b),
        .good_a_o   (good_a),
        .good_b_o   (good_b),
        .in_prot_o  (in_prot),
        .rd_key_o   (rd_key)
    );

    unlock_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .hit_a_i  (hit_a),
        .hit_b_i  (hit_b),
        .good_a_i (good_a),
        .good_b_i (good_b),
        .locked_o (locked_o)
    );

    unlock_write_qual #(
        .DATA_W (DATA_W)
    ) i_qual (
        .wr_en_i    (wr_en_i),
        .hit_a_i    (hit_a),
        .hit_b_i    (hit_b),
        .in_prot_i  (in_prot),
        .locked_i   (locked_o),
        .rd_key_i   (rd_key),
        .rd_data_i  (rd_data_i),
        .wr_allow_o (wr_allow_o),
        .key_wr_o   (key_wr_o),
        .rd_data_o  (rd_data_o)
    );

    AST_PROT_BLOCKED_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && in_prot && locked_o) |-> !wr_allow_o); // R3

    AST_KEY_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr_o |-> !wr_allow_o); // R5

    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_key |-> (rd_data_o == '0)); // R9

    AST_PARTIAL_KEY_A_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && hit_a && !(&wr_strb_i)) |=> locked_o); // R8

endmodule

// File: tb/test_key_unlock_gate.sv
module test_key_unlock_gate;

    localparam int CLK_P = 10;
    localparam logic [7:0]  KA = 8'h6C;
    localparam logic [7:0]  KB = 8'h70;
    localparam logic [31:0] K1 = 32'h83E7_0B13;
    localparam logic [31:0] K2 = 32'h95A4_F1E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_strb = 4'hF;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data_in = '0;
    logic [31:0] rd_data;
    logic        wr_allow, key_wr, locked;

    int n_cmp = 0;
    int n_bad = 0;
    int model_st = 0;   // 0 locked, 1 first key pending, 2 open
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    key_unlock_gate i_key_unlock_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .wr_strb_i  (wr_strb),
        .rd_addr_i  (rd_addr),
        .rd_data_i  (rd_data_in),
        .rd_data_o  (rd_data),
        .wr_allow_o (wr_allow),
        .key_wr_o   (key_wr),
        .locked_o   (locked)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic int next_st(int st, logic [7:0] a, logic [31:0] d, logic [3:0] s);
        bit full = (s == 4'hF);
        if (a == KA) begin
            if (!(full && d == K1)) return 0;
            return (st == 2) ? 2 : 1;
        end
        if (a == KB) begin
            if (full && d == K2 && st != 0) return 2;
            return 0;
        end
        return st;
    endfunction

    function automatic string tag_for(int st, logic [7:0] a, logic [31:0] d, logic [3:0] s);
        bit full = (s == 4'hF);
        if (a == KA) begin
            if (!full) return "R8";
            if (d != K1) return "R6";
            return (st == 2) ? "R11" : "R2";
        end
        if (a == KB) begin
            if (!full) return "R8";
            if (d != K2 || st == 0) return "R7";
            return (st == 2) ? "R11" : "R2";
        end
        return (st == 1) ? "R10" : "R4";
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        bit is_key, prot, exp_allow;
        string t;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
        #1;
        is_key    = (a == KA) || (a == KB);
        prot      = (a <= 8'h5F);
        exp_allow = !is_key && (!prot || model_st == 2);
        t = is_key ? "R5" : (prot ? "R3" : "R4");
        check(t, "wr_allow_o", {31'd0, wr_allow}, {31'd0, exp_allow});
        check(t, "key_wr_o", {31'd0, key_wr}, {31'd0, is_key});
        t = tag_for(model_st, a, d, s);
        @(posedge clk);
        model_st = next_st(model_st, a, d, s);
        #1;
        wr_en = 1'b0;
        check(t, "locked_o", {31'd0, locked}, {31'd0, (model_st != 2)});
    endtask

    task automatic go_state(input int s);
        wr(KA, 32'h0, 4'hF);
        if (s >= 1) wr(KA, K1, 4'hF);
        if (s == 2) wr(KB, K2, 4'hF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R1", "locked_o in reset", {31'd0, locked}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "locked_o after reset", {31'd0, locked}, 32'd1);
        check("R1", "wr_allow_o idle", {31'd0, wr_allow}, 32'd0);
        check("R1", "key_wr_o idle", {31'd0, key_wr}, 32'd0);

        // R2 with intervening writes, R10 on the pending state
        wr(KA, K1, 4'hF);
        check("R10", "locked_o after first key", {31'd0, locked}, 32'd1);
        wr(8'h10, 32'h1234, 4'hF);
        wr(8'h80, 32'h5678, 4'hF);
        wr(KB, K2, 4'hF);
        check("R2", "locked_o after sequence", {31'd0, locked}, 32'd0);

        // R1: reset relocks an open gate
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        model_st = 0;
        check("R1", "locked_o on reset while open", {31'd0, locked}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep: every state, every word address, several data values
        for (int st = 0; st < 3; st++) begin
            for (int w = 0; w < 64; w++) begin
                for (int v = 0; v < 4; v++) begin
                    logic [31:0] d;
                    case (v)
                        0: d = K1;
                        1: d = K2;
                        2: d = 32'h0;
                        default: d = 32'h5A5A_0000 ^ w;
                    endcase
                    go_state(st);
                    wr(8'(w * 4), d, 4'hF);
                end
            end
        end

        // R8: partial strobes on each key
        for (int b = 0; b < 15; b++) begin
            go_state(1);
            wr(KB, K2, 4'(b));
            go_state(2);
            wr(KA, K1, 4'(b));
        end

        // R7: second key twice in a row from locked, then wrong key second
        go_state(0);
        wr(KB, K2, 4'hF);
        wr(KB, K2, 4'hF);
        go_state(1);
        wr(KB, K1, 4'hF);

        // R9: read sweep over all word addresses
        for (int w = 0; w < 64; w++) begin
            logic [7:0] a;
            a = 8'(w * 4);
            @(negedge clk);
            rd_addr = a;
            rd_data_in = 32'hC0DE_0000 | w;
            #1;
            check("R9", "rd_data_o", rd_data,
                  ((a == KA) || (a == KB)) ? 32'h0 : (32'hC0DE_0000 | w));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule